// File: doc/BRIEF.md
# Block Transfer Address Sequencer

This block turns one multi-register load or store command into the stream of word addresses the memory side needs. A command carries a base address, a 16-bit register mask, two mode bits (before/after and up/down), a write-back request, a load/store flag and the index of the register that holds the base. For every register named in the mask the block emits one beat. Each beat carries the word address, the register index, a marker telling a non-sequential first access from the sequential accesses after it, and a last-beat flag. When the sequence is over, the block pulses `done` with the value the base register should hold afterwards, a write-back enable and an error flag.

Both the command input and the beat output are valid/ready streams. A command is taken on a cycle where `cmd_valid` and `cmd_ready` are both high. `cmd_ready` is high only while the block is idle, so there is one command in flight at a time. A beat is presented while `beat_valid` is high and is consumed on a cycle where `beat_ready` is also high. While `beat_ready` is low, every beat field holds its value and the sequence stalls. `done` and its result fields are plain status and are not back-pressured.

Top module: `blk_addr_seq`

## Requirements
- R1: `cmd_ready` is high exactly when the block is idle (not sequencing and not pulsing `done`). A command is accepted on a clock edge where `cmd_valid` and `cmd_ready` are both high.
- R2: With n registers in the mask and word size 4, the first beat address is: base when `cmd_pre`=0 and `cmd_up`=1; base+4 when `cmd_pre`=1 and `cmd_up`=1; base-4n+4 when `cmd_pre`=0 and `cmd_up`=0; base-4n when `cmd_pre`=1 and `cmd_up`=0.
- R3: Beats name the set bits of the mask in ascending index order, lowest index first, and each beat address is the previous one plus 4, in every mode.
- R4: The first beat of a command has `beat_seq`=0, every later beat has `beat_seq`=1, and `beat_last`=1 only on the final beat.
- R5: While `beat_valid` is high and `beat_ready` is low, `beat_addr`, `beat_reg` and `beat_seq` hold their values into the next cycle.
- R6: With `cmd_wback`=1 on a legal command that does not load its own base, `done_wb_en`=1 and `done_base` is base+4n for up modes or base-4n for down modes (base 0x1000 with three registers gives 0x100C or 0x0FF4).
- R7: With `cmd_wback`=0, `done_wb_en`=0 and `done_base` equals the command base.
- R8: A load (`cmd_load`=1) whose mask includes bit `cmd_base_idx` reports `done_wb_en`=0 and `done_base` equal to the command base, because the loaded word replaces the base. A store with the same mask still writes back.
- R9: A command with `cmd_base_idx`=15 raises `done_err`, emits no beat and reports `done_wb_en`=0.
- R10: A command with an all-zero mask raises `done_err`, emits no beat and reports `done_wb_en`=0.
- R11: `busy` is high in every cycle where a beat is presented and is low when idle or pulsing `done`.
- R12: `done` is high for one cycle, in the cycle after the last beat is consumed, or in the cycle after acceptance for an illegal command. The result fields are valid during that cycle.
- R13: During reset, `cmd_ready`=1 and `beat_valid`, `busy` and `done` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Block idle, command can be taken |
| cmd_base | input | 32 | Initial base address |
| cmd_list | input | 16 | Register mask, bit i names register i |
| cmd_pre | input | 1 | 1: step before each access, 0: after |
| cmd_up | input | 1 | 1: ascending addresses, 0: descending |
| cmd_wback | input | 1 | Request base update |
| cmd_load | input | 1 | 1: load, 0: store |
| cmd_base_idx | input | 4 | Index of the base register |
| beat_valid | output | 1 | Beat presented |
| beat_ready | input | 1 | Consumer takes the beat |
| beat_addr | output | 32 | Word address of this beat |
| beat_reg | output | 4 | Register index of this beat |
| beat_seq | output | 1 | 0 on the first beat, 1 on later beats |
| beat_last | output | 1 | Final beat of the command |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| done_err | output | 1 | Command was illegal |
| done_wb_en | output | 1 | Write `done_base` into the base register |
| done_base | output | 32 | Base value after the command |

## Verification
The hardest condition to reach from the ports is a beat that is held under back-pressure at the very moment it is the last one, with the completion pulse arriving late because of it. The consumer's ready signal is drawn at random every cycle, about one cycle in three low, so stalls fall on first, middle and last beats alike. Directed commands cover the full 16-register mask, the single-register mask where the first beat is also the last, a load that names its own base, and both illegal forms. Random commands spread the four modes and the write-back and load flags over random bases and masks.

// File: rtl/blkseq_pkg.sv
package blkseq_pkg;

  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_RUN  = 2'd1,
    SEQ_DONE = 2'd2
  } seq_state_e;

endpackage

// File: rtl/blkseq_plan.sv
// Combinational command planner: word count, first address, final base,
// write-back decision and legality.
module blkseq_plan #(
  parameter int AW   = 32,
  parameter int NREG = 16,
  parameter int WB   = 4,
  localparam int IW  = $clog2(NREG),
  localparam int CW  = $clog2(NREG + 1)
) (
  input  logic [AW-1:0]   base,
  input  logic [NREG-1:0] list,
  input  logic            pre,
  input  logic            up,
  input  logic            wback,
  input  logic            load,
  input  logic [IW-1:0]   base_idx,
  output logic [AW-1:0]   start_addr,
  output logic [AW-1:0]   final_base,
  output logic            wb_en,
  output logic            err
);

  logic [CW-1:0] cnt;
  logic [AW-1:0] span;
  logic          self_load;

  always_comb begin
    cnt = '0;
    for (int i = 0; i < NREG; i++) begin
      cnt = cnt + CW'(list[i]);
    end
  end

  assign span = AW'(cnt) * AW'(WB);

  always_comb begin
    unique case ({pre, up})
      2'b01:   start_addr = base;
      2'b11:   start_addr = base + AW'(WB);
      2'b00:   start_addr = base - span + AW'(WB);
      default: start_addr = base - span;
    endcase
  end

  assign err        = (base_idx == IW'(NREG - 1)) || (list == '0);
  assign self_load  = load && list[base_idx];
  assign wb_en      = wback && !err && !self_load;
  assign final_base = !wb_en ? base : (up ? base + span : base - span);

endmodule

// File: rtl/blkseq_pick.sv
// Lowest-set-bit selector over the remaining register mask.
module blkseq_pick #(
  parameter int NREG = 16,
  localparam int IW  = $clog2(NREG)
) (
  input  logic [NREG-1:0] mask,
  output logic [IW-1:0]   idx,
  output logic            any,
  output logic            one_left
);

  always_comb begin
    idx = '0;
    for (int i = NREG - 1; i >= 0; i--) begin
      if (mask[i]) idx = IW'(i);
    end
  end

  assign any      = |mask;
  assign one_left = any && ((mask & (mask - NREG'(1))) == '0);

endmodule

// File: rtl/blk_addr_seq.sv
module blk_addr_seq #(
  parameter int AW   = 32,
  parameter int NREG = 16,
  parameter int WB   = 4,
  localparam int IW  = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cmd_valid,
  output logic            cmd_ready,
  input  logic [AW-1:0]   cmd_base,
  input  logic [NREG-1:0] cmd_list,
  input  logic            cmd_pre,
  input  logic            cmd_up,
  input  logic            cmd_wback,
  input  logic            cmd_load,
  input  logic [IW-1:0]   cmd_base_idx,
  output logic            beat_valid,
  input  logic            beat_ready,
  output logic [AW-1:0]   beat_addr,
  output logic [IW-1:0]   beat_reg,
  output logic            beat_seq,
  output logic            beat_last,
  output logic            busy,
  output logic            done,
  output logic            done_err,
  output logic            done_wb_en,
  output logic [AW-1:0]   done_base
);
  import blkseq_pkg::*;

  seq_state_e      state_q;
  logic [AW-1:0]   addr_q;
  logic [NREG-1:0] mask_q;
  logic            first_q;
  logic [AW-1:0]   fin_q;
  logic            wb_q;
  logic            err_q;

  logic [AW-1:0]   p_start;
  logic [AW-1:0]   p_final;
  logic            p_wb;
  logic            p_err;
  logic [IW-1:0]   pick_idx;
  logic            pick_any;
  logic            pick_one;
  logic            accept;
  logic            step;
  logic [NREG-1:0] clr_bit;

  blkseq_plan #(.AW(AW), .NREG(NREG), .WB(WB)) u_plan (
    .base       (cmd_base),
    .list       (cmd_list),
    .pre        (cmd_pre),
    .up         (cmd_up),
    .wback      (cmd_wback),
    .load       (cmd_load),
    .base_idx   (cmd_base_idx),
    .start_addr (p_start),
    .final_base (p_final),
    .wb_en      (p_wb),
    .err        (p_err)
  );

  blkseq_pick #(.NREG(NREG)) u_pick (
    .mask     (mask_q),
    .idx      (pick_idx),
    .any      (pick_any),
    .one_left (pick_one)
  );

  assign cmd_ready = (state_q == SEQ_IDLE);
  assign accept    = cmd_valid && cmd_ready;
  assign step      = (state_q == SEQ_RUN) && beat_ready && pick_any;
  assign clr_bit   = NREG'(1) << pick_idx;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      addr_q  <= '0;
      mask_q  <= '0;
      first_q <= 1'b0;
      fin_q   <= '0;
      wb_q    <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      unique case (state_q)
        SEQ_IDLE: begin
          if (accept) begin
            addr_q  <= p_start;
            mask_q  <= p_err ? '0 : cmd_list;
            first_q <= 1'b1;
            fin_q   <= p_final;
            wb_q    <= p_wb;
            err_q   <= p_err;
            state_q <= p_err ? SEQ_DONE : SEQ_RUN;
          end
        end
        SEQ_RUN: begin
          if (step) begin
            addr_q  <= addr_q + AW'(WB);
            mask_q  <= mask_q & ~clr_bit;
            first_q <= 1'b0;
            if (pick_one) state_q <= SEQ_DONE;
          end
        end
        default: state_q <= SEQ_IDLE;
      endcase
    end
  end

  assign beat_valid = (state_q == SEQ_RUN);
  assign beat_addr  = addr_q;
  assign beat_reg   = pick_idx;
  assign beat_seq   = !first_q;
  assign beat_last  = pick_one;
  assign busy       = (state_q == SEQ_RUN);
  assign done       = (state_q == SEQ_DONE);
  assign done_err   = err_q;
  assign done_wb_en = wb_q;
  assign done_base  = fin_q;

endmodule

// File: rtl/blkseq_chk.sv
module blkseq_chk #(
  parameter int AW   = 32,
  parameter int NREG = 16,
  parameter int WB   = 4,
  localparam int IW  = $clog2(NREG)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cmd_ready,
  input logic          beat_valid,
  input logic          beat_ready,
  input logic [AW-1:0] beat_addr,
  input logic [IW-1:0] beat_reg,
  input logic          beat_seq,
  input logic          beat_last,
  input logic          busy,
  input logic          done
);

  logic hs;
  assign hs = beat_valid && beat_ready;

  a_r1_ready_idle: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready |-> (!busy && !done));

  a_r3_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
    (hs && !beat_last) |=> (beat_valid && beat_addr == $past(beat_addr) + AW'(WB)));

  a_r3_ascend: assert property (@(posedge clk) disable iff (!rst_n)
    (hs && !beat_last) |=> (beat_reg > $past(beat_reg)));

  a_r4_first_nonseq: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(beat_valid) |-> !beat_seq);

  a_r4_later_seq: assert property (@(posedge clk) disable iff (!rst_n)
    (hs && !beat_last) |=> beat_seq);

  a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_valid && !beat_ready) |=>
      (beat_valid && $stable(beat_addr) && $stable(beat_reg) && $stable(beat_seq)));

  a_r11_busy_beat: assert property (@(posedge clk) disable iff (!rst_n)
    beat_valid |-> busy);

  a_r12_done_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    (hs && beat_last) |=> (done && !busy));

  a_r12_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

endmodule

bind blk_addr_seq blkseq_chk #(.AW(AW), .NREG(NREG), .WB(WB)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cmd_ready  (cmd_ready),
  .beat_valid (beat_valid),
  .beat_ready (beat_ready),
  .beat_addr  (beat_addr),
  .beat_reg   (beat_reg),
  .beat_seq   (beat_seq),
  .beat_last  (beat_last),
  .busy       (busy),
  .done       (done)
);

// File: tb/blk_addr_seq_test.sv
module blk_addr_seq_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [31:0] cmd_base = '0;
  logic [15:0] cmd_list = '0;
  logic        cmd_pre = 1'b0;
  logic        cmd_up = 1'b0;
  logic        cmd_wback = 1'b0;
  logic        cmd_load = 1'b0;
  logic [3:0]  cmd_base_idx = '0;
  logic        beat_valid;
  logic        beat_ready = 1'b0;
  logic [31:0] beat_addr;
  logic [3:0]  beat_reg;
  logic        beat_seq;
  logic        beat_last;
  logic        busy;
  logic        done;
  logic        done_err;
  logic        done_wb_en;
  logic [31:0] done_base;

  int n_chk  = 0;
  int n_fail = 0;
  int cycles = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  blk_addr_seq uut (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_base(cmd_base), .cmd_list(cmd_list), .cmd_pre(cmd_pre), .cmd_up(cmd_up),
    .cmd_wback(cmd_wback), .cmd_load(cmd_load), .cmd_base_idx(cmd_base_idx),
    .beat_valid(beat_valid), .beat_ready(beat_ready), .beat_addr(beat_addr),
    .beat_reg(beat_reg), .beat_seq(beat_seq), .beat_last(beat_last),
    .busy(busy), .done(done), .done_err(done_err), .done_wb_en(done_wb_en),
    .done_base(done_base)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%h expected=%h", cycles, 0);
      summary();
    end
  end

  function automatic int count_bits(input logic [15:0] l);
    int c = 0;
    for (int i = 0; i < 16; i++) c += l[i];
    return c;
  endfunction

  function automatic logic [31:0] exp_start(input logic [31:0] b, input int n,
                                            input bit pre, input bit up);
    if (up) return pre ? b + 32'd4 : b;
    return pre ? b - 32'(4 * n) : b - 32'(4 * n) + 32'd4;
  endfunction

  task automatic run_cmd(input logic [31:0] b, input logic [15:0] l, input bit pre,
                         input bit up, input bit wb, input bit ld, input logic [3:0] bi,
                         input int ready_pct);
    int n, k, guard;
    int regs[16];
    bit e_err, e_wb, stalled;
    logic [31:0] e_start, e_fin, st_addr;
    logic [3:0]  st_reg;
    n = count_bits(l);
    k = 0;
    for (int i = 0; i < 16; i++) if (l[i]) begin regs[k] = i; k++; end
    k = 0;
    e_err   = (bi == 4'd15) || (l == 16'd0);
    e_wb    = wb && !e_err && !(ld && l[bi]);
    e_start = exp_start(b, n, pre, up);
    e_fin   = !e_wb ? b : (up ? b + 32'(4 * n) : b - 32'(4 * n));
    @(negedge clk);
    chk(cmd_ready == 1'b1, "R1 ready when idle", cmd_ready, 1);
    cmd_base = b; cmd_list = l; cmd_pre = pre; cmd_up = up;
    cmd_wback = wb; cmd_load = ld; cmd_base_idx = bi; cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    chk(cmd_ready == 1'b0, "R1 ready low after accept", cmd_ready, 0);
    stalled = 0;
    guard = 0;
    while (1) begin
      beat_ready = (($urandom % 100) < 32'(ready_pct));
      if (stalled) begin
        chk(beat_addr == st_addr && beat_reg == st_reg, "R5 hold under stall",
            beat_addr, st_addr);
      end
      stalled = 0;
      if (done) begin
        chk(k == n && !e_err || k == 0 && e_err, "R9 R10 beat count", k, e_err ? 0 : n);
        chk(done_err == e_err, "R9 R10 error flag", done_err, e_err);
        chk(done_wb_en == e_wb, "R6 R7 R8 write-back enable", done_wb_en, e_wb);
        chk(done_base == e_fin, "R6 R7 R8 final base", done_base, e_fin);
        chk(busy == 1'b0, "R11 busy low at done", busy, 0);
        break;
      end
      if (beat_valid) begin
        chk(busy == 1'b1, "R11 busy with beat", busy, 1);
        if (k >= n || e_err) begin
          chk(1'b0, "R9 R10 unexpected beat", beat_addr, 0);
          k++;
        end else if (beat_ready) begin
          chk(beat_addr == e_start + 32'(4 * k), "R2 R3 beat address", beat_addr,
              e_start + 32'(4 * k));
          chk(beat_reg == 4'(regs[k]), "R3 register order", beat_reg, regs[k]);
          chk(beat_seq == (k != 0), "R4 sequential marker", beat_seq, k != 0);
          chk(beat_last == (k == n - 1), "R4 last flag", beat_last, k == n - 1);
          k++;
        end else begin
          stalled = 1; st_addr = beat_addr; st_reg = beat_reg;
        end
      end
      guard++;
      if (guard > 400) begin
        chk(1'b0, "R12 done never seen", guard, 0);
        break;
      end
      @(negedge clk);
    end
    @(negedge clk);
    beat_ready = 1'b0;
    chk(done == 1'b0 && cmd_ready == 1'b1, "R12 one-cycle done", done, 0);
  endtask

  initial begin
    void'($urandom(32'h5EED_0A11));
    repeat (3) @(negedge clk);
    chk(cmd_ready == 1'b1, "R13 reset ready", cmd_ready, 1);
    chk(beat_valid == 1'b0, "R13 reset beat_valid", beat_valid, 0);
    chk(busy == 1'b0 && done == 1'b0, "R13 reset busy/done", {busy, done}, 0);
    rst_n = 1'b1;
    // R6 documented example, all four modes
    run_cmd(32'h1000, 16'h0026, 1'b0, 1'b1, 1'b1, 1'b0, 4'd0, 70);
    run_cmd(32'h1000, 16'h0026, 1'b1, 1'b1, 1'b1, 1'b0, 4'd0, 70);
    run_cmd(32'h1000, 16'h0026, 1'b0, 1'b0, 1'b1, 1'b0, 4'd0, 70);
    run_cmd(32'h1000, 16'h0026, 1'b1, 1'b0, 1'b1, 1'b1, 4'd0, 70);
    // R7 no write-back
    run_cmd(32'h2000, 16'h00F0, 1'b1, 1'b1, 1'b0, 1'b1, 4'd2, 100);
    // R8 load including base, then store including base
    run_cmd(32'h3000, 16'h0104, 1'b0, 1'b1, 1'b1, 1'b1, 4'd2, 70);
    run_cmd(32'h3000, 16'h0104, 1'b0, 1'b1, 1'b1, 1'b0, 4'd2, 70);
    // R9 base index 15, R10 empty list
    run_cmd(32'h4000, 16'h0003, 1'b0, 1'b1, 1'b1, 1'b0, 4'd15, 70);
    run_cmd(32'h4000, 16'h0000, 1'b1, 1'b0, 1'b1, 1'b1, 4'd3, 70);
    // R4 single register, R5 heavy stall, full list
    run_cmd(32'h5000, 16'h8000, 1'b1, 1'b0, 1'b1, 1'b0, 4'd1, 30);
    run_cmd(32'h6000, 16'hFFFF, 1'b0, 1'b0, 1'b1, 1'b0, 4'd13, 40);
    run_cmd(32'h0000_0008, 16'hFFFF, 1'b1, 1'b0, 1'b1, 1'b0, 4'd14, 60);
    for (int t = 0; t < 60; t++) begin
      logic [15:0] l;
      logic [3:0]  bi;
      l  = 16'($urandom);
      if ($urandom % 10 == 0) l = '0;
      bi = 4'($urandom % 16);
      run_cmd({$urandom, 2'b00} & 32'hFFFF_FFFC, l, 1'($urandom), 1'($urandom),
              1'($urandom), 1'($urandom), bi, 65);
    end
    summary();
  end

endmodule